// File: doc/BRIEF.md
# Line Remote Error Indication Processor

This block handles the line-layer remote error indication byte of a SONET/SDH framer in both directions. On the transmit side it loads the outgoing byte once per frame. The byte normally carries the number of B2 parity errors found on the incoming line. It can be forced to zero. A software-supplied error pattern can also replace it for a single frame.

On the receive side, every frame's byte is decoded. A legal nonzero value raises a status bit. The value is then added into a saturating accumulator. Accumulation pauses while any line defect is present: loss of signal, loss of frame, line AIS or line RDI. A one-second pulse moves the accumulated total into a holding register for software to read. The same pulse restarts the accumulator from the current frame's contribution, so no count is lost at the boundary. Parity computation is done elsewhere; this block only receives the count.

Top module: `rei_line_proc`

## Requirements
- R1: On a cycle with `frame_stb` high and `tx_rei_en` high, `tx_rei_byte` takes the value of `b2_err_cnt` on the following cycle. `tx_rei_byte` changes on no other cycle.
- R2: On a frame with `tx_rei_en` low and no insertion pending, `tx_rei_byte` becomes 00h.
- R3: A rising edge of `err_ins` arms a one-shot. The next frame strobe, including one in the same cycle as the edge, loads `err_pat` into `tx_rei_byte` and clears the one-shot. Holding `err_ins` high arms no further insertion.
- R4: An armed insertion takes priority over `tx_rei_en` low.
- R5: At each frame strobe, `rx_rei_flag` becomes 1 when `rx_rei_byte` is between 1 and MAX_REI inclusive, and 0 otherwise. The flag holds between frames.
- R6: A received value above MAX_REI contributes zero to the accumulator.
- R7: When any of `los`, `lof`, `ais_l` or `rdi_l` is high at a frame strobe, that frame contributes zero to the accumulator.
- R8: On a cycle with `sec_pulse` high, `rei_hold` takes the accumulator total as it stood before that cycle. The accumulator restarts at that cycle's frame contribution, or at zero if there is no frame strobe. `rei_hold` changes on no other cycle.
- R9: The accumulator, CNT_W bits wide, saturates at all-ones and does not wrap.
- R10: While `rst` is high, every output and the accumulator clear to zero on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| frame_stb | input | 1 | one-cycle pulse per frame |
| b2_err_cnt | input | BYTE_W | B2 errors found in the current received frame |
| tx_rei_en | input | 1 | enables error reporting on transmit |
| err_ins | input | 1 | pattern insertion request, acts on its rising edge |
| err_pat | input | BYTE_W | pattern used for insertion |
| rx_rei_byte | input | BYTE_W | received remote error indication byte |
| los | input | 1 | loss of signal |
| lof | input | 1 | loss of frame |
| ais_l | input | 1 | line alarm indication signal |
| rdi_l | input | 1 | line remote defect indication |
| sec_pulse | input | 1 | one-second latch pulse |
| tx_rei_byte | output | BYTE_W | outgoing remote error indication byte |
| rx_rei_flag | output | 1 | received legal nonzero indication |
| rei_hold | output | CNT_W | latched one-second count |

## Verification
The bench keeps MAX_REI at its default of 24 and shrinks CNT_W to 10. This brings saturation within reach after about forty frames at the largest legal value, so R9 is exercised in a short run. BYTE_W stays at 8. The stimulus covers received values just above MAX_REI, and one-second pulses both with and without a coinciding frame strobe.

// File: rtl/rei_pkg.sv
package rei_pkg;
  typedef struct packed {
    logic los;
    logic lof;
    logic ais;
    logic rdi;
  } line_defect_t;

  function automatic logic any_defect(input line_defect_t d);
    return d.los | d.lof | d.ais | d.rdi;
  endfunction
endpackage

// File: rtl/rei_tx_gen.sv
module rei_tx_gen #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              tx_en,
  input  logic              err_ins,
  input  logic [BYTE_W-1:0] err_pat,
  input  logic [BYTE_W-1:0] b2_cnt,
  output logic [BYTE_W-1:0] tx_byte
);
  logic ins_d;
  logic pend_q;
  logic ins_rise;
  logic use_pat;

  assign ins_rise = err_ins & ~ins_d;
  assign use_pat  = pend_q | ins_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ins_d   <= 1'b0;
      pend_q  <= 1'b0;
      tx_byte <= '0;
    end else begin
      ins_d <= err_ins;
      if (frame_stb) begin
        pend_q <= 1'b0;
        if (use_pat)
          tx_byte <= err_pat;
        else if (tx_en)
          tx_byte <= b2_cnt;
        else
          tx_byte <= '0;
      end else begin
        pend_q <= use_pat;
      end
    end
  end
endmodule

// File: rtl/rei_rx_decode.sv
module rei_rx_decode
  import rei_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int MAX_REI = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  line_defect_t      defect,
  output logic              flag,
  output logic [BYTE_W-1:0] contrib
);
  localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(MAX_REI);

  logic              legal;
  logic [BYTE_W-1:0] clamped;

  assign legal   = (rx_byte <= LIMIT);
  assign clamped = legal ? rx_byte : '0;
  assign contrib = any_defect(defect) ? '0 : clamped;

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (frame_stb)
      flag <= (clamped != '0);
  end
endmodule

// File: rtl/rei_accum.sv
module rei_accum #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              sec_pulse,
  input  logic [BYTE_W-1:0] contrib,
  output logic [CNT_W-1:0]  acc,
  output logic [CNT_W-1:0]  hold
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] add_val;

  assign add_val = frame_stb ? CNT_W'(contrib) : '0;
  assign sum     = {1'b0, acc} + {1'b0, add_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      hold <= '0;
    end else if (sec_pulse) begin
      hold <= acc;
      acc  <= add_val;
    end else if (sum[CNT_W]) begin
      acc <= '1;
    end else begin
      acc <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rei_line_proc.sv
module rei_line_proc
  import rei_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 20,
  parameter int MAX_REI = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [BYTE_W-1:0] b2_err_cnt,
  input  logic              tx_rei_en,
  input  logic              err_ins,
  input  logic [BYTE_W-1:0] err_pat,
  input  logic [BYTE_W-1:0] rx_rei_byte,
  input  logic              los,
  input  logic              lof,
  input  logic              ais_l,
  input  logic              rdi_l,
  input  logic              sec_pulse,
  output logic [BYTE_W-1:0] tx_rei_byte,
  output logic              rx_rei_flag,
  output logic [CNT_W-1:0]  rei_hold
);
  line_defect_t      defect;
  logic [BYTE_W-1:0] contrib;
  logic [CNT_W-1:0]  acc_q;

  assign defect = '{los: los, lof: lof, ais: ais_l, rdi: rdi_l};

  rei_tx_gen #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .tx_en(tx_rei_en),
    .err_ins(err_ins), .err_pat(err_pat), .b2_cnt(b2_err_cnt),
    .tx_byte(tx_rei_byte)
  );

  rei_rx_decode #(.BYTE_W(BYTE_W), .MAX_REI(MAX_REI)) u_rx (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_byte(rx_rei_byte),
    .defect(defect), .flag(rx_rei_flag), .contrib(contrib)
  );

  rei_accum #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .sec_pulse(sec_pulse),
    .contrib(contrib), .acc(acc_q), .hold(rei_hold)
  );
endmodule

// File: rtl/rei_line_chk.sv
module rei_line_chk #(
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 20,
  parameter int MAX_REI = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_stb,
  input logic              sec_pulse,
  input logic [BYTE_W-1:0] rx_rei_byte,
  input logic              los,
  input logic              lof,
  input logic              ais_l,
  input logic              rdi_l,
  input logic [BYTE_W-1:0] tx_rei_byte,
  input logic              rx_rei_flag,
  input logic [CNT_W-1:0]  rei_hold,
  input logic [CNT_W-1:0]  acc
);
  // R1
  tx_only_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(tx_rei_byte));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(rx_rei_flag));

  // R5
  flag_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && rx_rei_byte > BYTE_W'(MAX_REI)) |=> !rx_rei_flag);

  // R7
  defect_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !sec_pulse && (los || lof || ais_l || rdi_l)) |=> $stable(acc));

  // R8
  hold_only_on_sec_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |=> $stable(rei_hold));

  // R8
  hold_takes_acc_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> rei_hold == $past(acc));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |=> acc >= $past(acc));
endmodule

bind rei_line_proc rei_line_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .MAX_REI(MAX_REI)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .sec_pulse(sec_pulse),
  .rx_rei_byte(rx_rei_byte), .los(los), .lof(lof), .ais_l(ais_l), .rdi_l(rdi_l),
  .tx_rei_byte(tx_rei_byte), .rx_rei_flag(rx_rei_flag), .rei_hold(rei_hold),
  .acc(acc_q)
);

// File: tb/test_rei_line_proc.sv
module test_rei_line_proc;
  localparam int CLK_P   = 10;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 10;
  localparam int MAX_REI = 24;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0, tx_rei_en = 1'b0, err_ins = 1'b0, sec_pulse = 1'b0;
  logic los = 1'b0, lof = 1'b0, ais_l = 1'b0, rdi_l = 1'b0;
  logic [BYTE_W-1:0] b2_err_cnt = '0, err_pat = '0, rx_rei_byte = '0;
  logic [BYTE_W-1:0] tx_rei_byte;
  logic              rx_rei_flag;
  logic [CNT_W-1:0]  rei_hold;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_tx = 0, m_flag = 0, m_hold = 0, m_acc = 0, m_prev = 0, m_pend = 0;

  always #(CLK_P/2) clk = ~clk;

  rei_line_proc #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .MAX_REI(MAX_REI)) i_rei_line_proc (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .b2_err_cnt(b2_err_cnt),
    .tx_rei_en(tx_rei_en), .err_ins(err_ins), .err_pat(err_pat),
    .rx_rei_byte(rx_rei_byte), .los(los), .lof(lof), .ais_l(ais_l), .rdi_l(rdi_l),
    .sec_pulse(sec_pulse), .tx_rei_byte(tx_rei_byte), .rx_rei_flag(rx_rei_flag),
    .rei_hold(rei_hold)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int rise, contrib, rxv;
    if (rst) begin
      m_tx = 0; m_flag = 0; m_hold = 0; m_acc = 0; m_prev = 0; m_pend = 0;
      return;
    end
    rise = (err_ins && !m_prev) ? 1 : 0;
    m_prev = err_ins;
    rxv = int'(rx_rei_byte);
    contrib = (rxv <= MAX_REI) ? rxv : 0;
    if (frame_stb) begin
      if (m_pend || rise) m_tx = int'(err_pat);
      else m_tx = tx_rei_en ? int'(b2_err_cnt) : 0;
      m_pend = 0;
      m_flag = (contrib != 0) ? 1 : 0;
    end else if (rise) m_pend = 1;
    if (los || lof || ais_l || rdi_l) contrib = 0;
    if (!frame_stb) contrib = 0;
    if (sec_pulse) begin
      m_hold = m_acc;
      m_acc = contrib;
    end else begin
      m_acc = m_acc + contrib;
      if (m_acc > CNT_MAX) m_acc = CNT_MAX;
    end
  endtask

  // one clock: model updates at the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R1/R2/R3/R4 tx byte", int'(tx_rei_byte), m_tx);
    check("R5 rx flag", int'(rx_rei_flag), m_flag);
    check("R6/R7/R8/R9 hold", int'(rei_hold), m_hold);
  endtask

  task automatic frame(input int b2, input int rx);
    b2_err_cnt = BYTE_W'(b2); rx_rei_byte = BYTE_W'(rx); frame_stb = 1'b1;
    tick();
    frame_stb = 1'b0;
    tick(); tick();
  endtask

  task automatic second();
    sec_pulse = 1'b1; tick(); sec_pulse = 1'b0; tick();
  endtask

  initial begin
    repeat (3) tick();
    // R10: reset state
    check("R10 tx reset", int'(tx_rei_byte), 0);
    check("R10 flag reset", int'(rx_rei_flag), 0);
    check("R10 hold reset", int'(rei_hold), 0);
    rst = 1'b0; tick();

    // R1 enabled reporting, R5 legal values
    tx_rei_en = 1'b1;
    frame(3, 5); frame(17, 7); frame(0, 0);
    check("R1 tx holds b2 count", int'(tx_rei_byte), 0);
    second();
    check("R8 hold sums 5+7", int'(rei_hold), 12);

    // R2 disabled
    tx_rei_en = 1'b0;
    frame(9, 1);
    check("R2 tx zero when disabled", int'(tx_rei_byte), 0);

    // R3/R4 insertion edge, held high
    err_pat = 8'hA5; err_ins = 1'b1; tick();
    frame(9, 2);
    check("R4 pattern overrides disable", int'(tx_rei_byte), 8'hA5);
    frame(9, 2);
    check("R3 no repeat while held", int'(tx_rei_byte), 0);
    err_ins = 1'b0; tick();
    tx_rei_en = 1'b1; err_pat = 8'h3C; err_ins = 1'b1;
    frame(6, 24);  // edge in the same cycle as the strobe
    check("R3 same-cycle insertion", int'(tx_rei_byte), 8'h3C);
    frame(6, 24);
    check("R3 back to count", int'(tx_rei_byte), 6);
    err_ins = 1'b0;

    // R5/R6 illegal values
    frame(1, 25);
    check("R6 above limit flag", int'(rx_rei_flag), 0);
    frame(1, 255); frame(1, 24);
    check("R5 limit is legal", int'(rx_rei_flag), 1);
    second();

    // R7 each defect
    los = 1'b1; frame(0, 10); los = 1'b0;
    lof = 1'b1; frame(0, 10); lof = 1'b0;
    ais_l = 1'b1; frame(0, 10); ais_l = 1'b0;
    rdi_l = 1'b1; frame(0, 10); rdi_l = 1'b0;
    frame(0, 4);
    second();
    check("R7 defects suppress", int'(rei_hold), 4);

    // R8 pulse with frame
    frame(0, 3);
    rx_rei_byte = 8'd9; frame_stb = 1'b1; sec_pulse = 1'b1; tick();
    frame_stb = 1'b0; sec_pulse = 1'b0; tick();
    check("R8 latch excludes coincident frame", int'(rei_hold), 3);
    second();
    check("R8 restart keeps coincident frame", int'(rei_hold), 9);

    // R9 saturation
    for (int i = 0; i < 50; i++) frame(0, 24);
    second();
    check("R9 saturated", int'(rei_hold), CNT_MAX);

    // R10 reset again mid-run
    frame(5, 5);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R10 flag after reset", int'(rx_rei_flag), 0);
    tick();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule